// File: doc/BRIEF.md
# Capture Timer with Control Register

This block is a free-running event timer with a single byte-wide control and status register on a simple register bus. Software starts the timer by setting a run bit. The counter then advances by one on every cycle in which the clock enable is high. A rising edge on the capture input copies the current count into a holding register, stops the timer and raises a pending flag. If the counter wraps past its maximum value, an overflow flag is raised.

Both flags are sticky. Software clears a flag by writing 0 to its bit, and they share one level interrupt that an enable bit gates. A mode bit selects whether starting the timer resets the count or resumes from the value it held. Software reads back the held capture value and the live count as bytes.

The register map uses a 3-bit address. Address 0 is the control register. Addresses 1 and 2 return the low and high bytes of the held capture value. Addresses 3 and 4 return the low and high bytes of the live count. All other addresses read as zero.

Top module: `capture_timer`

## Requirements
- R1: The control register at address 0 holds, from bit 4 down to bit 0: mode, run, overflow, pending, enable. Bits 7 to 5 always read 0 and writes to them have no effect. After reset every readable location reads 0 and irq is low.
- R2: While run is 1, the count increments by one on each clock cycle with tick_en high. The count's low and high bytes read at addresses 3 and 4.
- R3: A write that takes run from 0 to 1 clears the count to 0 when the written mode bit is 0, and keeps the count when it is 1. Writing run as 1 while already running does not restart or clear the count.
- R4: Writing run as 0 stops the timer, and the count then stays frozen whatever tick_en does.
- R5: cap_in passes through two synchroniser flops. A synchronised rising edge seen while run is 1 acts at the third rising clk edge after cap_in rises. At that edge it copies the count into the holding register (addresses 1 and 2), clears run and sets pending. Edges seen while run is 0 are ignored.
- R6: The overflow flag sets when a counting cycle takes the count from all ones to 0. Writing 0 to bit 2 clears it, and writing 1 to bit 2 leaves it unchanged.
- R7: The pending flag is set only by a capture. Writing 0 to bit 1 clears it, and writing 1 to bit 1 leaves it unchanged.
- R8: irq is a level equal to (overflow OR pending) AND enable.
- R9: When a hardware set of a flag and a software clear of that flag fall in the same cycle, the flag ends up set. When a capture and a write of run as 1 coincide, run ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one increment per high cycle while running |
| cap_in | input | 1 | Asynchronous capture event input |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Shared interrupt request, level |

## Verification
The assertions assume that cap_in either stays stable across the synchroniser or rises cleanly. They also assume that a write strobe lasts exactly one cycle, and that tick_en has no relation to the bus. The stimulus raises and lowers bus_wr and cap_in only at falling clock edges. It holds cap_in high for several cycles so that the synchronised edge is seen once. It keeps tick_en low while it checks a capture, so that the held count can be predicted exactly. The collision case places the write strobe on the exact edge at which the capture acts, which is the third rising edge after cap_in rises.

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cap_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);

  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_HLO   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HHI   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLO   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CHI   = ADDR_W'(4);
  localparam int B_MODE = 4;
  localparam int B_RUN  = 3;
  localparam int B_OVF  = 2;
  localparam int B_PND  = 1;
  localparam int B_IEN  = 0;

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q, hold_q;
  logic             mode_q, run_q, ovf_q, pnd_q, ien_q;
  logic [15:0]      cnt16, hold16;

  wire cap_edge = sync_q[1] & ~sync_q[2];
  wire ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  wire start    = ctrl_wr && bus_wdata[B_RUN] && !run_q;
  wire cap_evt  = run_q && cap_edge;
  wire inc      = run_q && tick_en && !cap_evt;
  wire wrap     = inc && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], cap_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          cnt_q <= '0;
    else if (start && !bus_wdata[B_MODE]) cnt_q <= '0;
    else if (inc)                        cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       hold_q <= '0;
    else if (cap_evt) hold_q <= cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       run_q <= 1'b0;
    else if (cap_evt) run_q <= 1'b0;
    else if (ctrl_wr) run_q <= bus_wdata[B_RUN];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 1'b0;
      ien_q  <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q <= bus_wdata[B_MODE];
      ien_q  <= bus_wdata[B_IEN];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            ovf_q <= 1'b0;
    else if (wrap)                         ovf_q <= 1'b1;
    else if (ctrl_wr && !bus_wdata[B_OVF]) ovf_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            pnd_q <= 1'b0;
    else if (cap_evt)                      pnd_q <= 1'b1;
    else if (ctrl_wr && !bus_wdata[B_PND]) pnd_q <= 1'b0;

  assign irq    = (ovf_q | pnd_q) & ien_q;
  assign cnt16  = 16'(cnt_q);
  assign hold16 = 16'(hold_q);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {3'b000, mode_q, run_q, ovf_q, pnd_q, ien_q};
      A_HLO:   bus_rdata = hold16[7:0];
      A_HHI:   bus_rdata = hold16[15:8];
      A_CLO:   bus_rdata = cnt16[7:0];
      A_CHI:   bus_rdata = cnt16[15:8];
      default: bus_rdata = 8'h00;
    endcase
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q != CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !bus_wdata[B_MODE]) |=> cnt_q == '0); // R3
  AST_START_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bus_wdata[B_MODE]) |=> $stable(cnt_q)); // R3
  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> $stable(cnt_q)); // R4
  AST_HOLD_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(hold_q)); // R5
  AST_CAPTURE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (!run_q && pnd_q)); // R5
  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !$rose(pnd_q)); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ovf_q && cnt_q == '0)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(ctrl_wr && !bus_wdata[B_OVF])) |=> ovf_q); // R6
  AST_PND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_q && !(ctrl_wr && !bus_wdata[B_PND])) |=> pnd_q); // R7
  AST_IRQ_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && ien_q && !(ctrl_wr && !bus_wdata[B_IEN])) |=> irq); // R8
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && ctrl_wr) |=> (pnd_q && !run_q)); // R9

endmodule

// File: tb/capture_timer_tb.sv
module capture_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       cap_in = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  capture_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_in(cap_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_T = 2'd2, OP_C = 2'd3;
  // {req[3:0], op[1:0], addr[2:0], data[7:0], irq, n[15:0]}
  localparam int NV = 36;
  localparam logic [33:0] VEC [NV] = '{
    {4'd3, OP_W, 3'd0, 8'h08, 1'b0, 16'd0},
    {4'd2, OP_T, 3'd0, 8'h00, 1'b0, 16'd10},
    {4'd2, OP_R, 3'd3, 8'h0A, 1'b0, 16'd0},
    {4'd1, OP_R, 3'd0, 8'h08, 1'b0, 16'd0},
    {4'd5, OP_C, 3'd0, 8'h00, 1'b0, 16'd0},
    {4'd5, OP_R, 3'd0, 8'h02, 1'b0, 16'd0},
    {4'd5, OP_R, 3'd1, 8'h0A, 1'b0, 16'd0},
    {4'd5, OP_R, 3'd2, 8'h00, 1'b0, 16'd0},
    {4'd4, OP_T, 3'd0, 8'h00, 1'b0, 16'd5},
    {4'd4, OP_R, 3'd3, 8'h0A, 1'b0, 16'd0},
    {4'd3, OP_W, 3'd0, 8'h19, 1'b0, 16'd0},
    {4'd7, OP_R, 3'd0, 8'h19, 1'b0, 16'd0},
    {4'd3, OP_T, 3'd0, 8'h00, 1'b0, 16'd300},
    {4'd3, OP_R, 3'd3, 8'h36, 1'b0, 16'd0},
    {4'd3, OP_R, 3'd4, 8'h01, 1'b0, 16'd0},
    {4'd4, OP_W, 3'd0, 8'h11, 1'b0, 16'd0},
    {4'd4, OP_T, 3'd0, 8'h00, 1'b0, 16'd4},
    {4'd4, OP_R, 3'd3, 8'h36, 1'b0, 16'd0},
    {4'd3, OP_W, 3'd0, 8'h08, 1'b0, 16'd0},
    {4'd3, OP_R, 3'd3, 8'h00, 1'b0, 16'd0},
    {4'd3, OP_R, 3'd0, 8'h08, 1'b0, 16'd0},
    {4'd2, OP_T, 3'd0, 8'h00, 1'b0, 16'd3},
    {4'd1, OP_W, 3'd0, 8'hE8, 1'b0, 16'd0},
    {4'd1, OP_R, 3'd0, 8'h08, 1'b0, 16'd0},
    {4'd3, OP_R, 3'd3, 8'h03, 1'b0, 16'd0},
    {4'd5, OP_C, 3'd0, 8'h00, 1'b0, 16'd0},
    {4'd5, OP_R, 3'd0, 8'h02, 1'b0, 16'd0},
    {4'd5, OP_R, 3'd1, 8'h03, 1'b0, 16'd0},
    {4'd8, OP_W, 3'd0, 8'h03, 1'b0, 16'd0},
    {4'd8, OP_R, 3'd0, 8'h03, 1'b1, 16'd0},
    {4'd7, OP_W, 3'd0, 8'h01, 1'b0, 16'd0},
    {4'd7, OP_R, 3'd0, 8'h01, 1'b0, 16'd0},
    {4'd5, OP_C, 3'd0, 8'h00, 1'b0, 16'd0},
    {4'd5, OP_R, 3'd0, 8'h01, 1'b0, 16'd0},
    {4'd5, OP_R, 3'd1, 8'h03, 1'b0, 16'd0},
    {4'd5, OP_R, 3'd3, 8'h03, 1'b0, 16'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp_d, input logic exp_irq,
                    input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp_d, req, bus_rdata, exp_d);
    chk(irq == exp_irq, {req, " irq"}, irq, exp_irq);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic capture();
    @(negedge clk);
    cap_in = 1'b1;
    repeat (5) @(negedge clk);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, every location zero
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, 1'b0, "R1 reset");

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [1:0]  op;
      logic [2:0]  ad;
      logic [7:0]  dt;
      logic        iq;
      logic [15:0] n;
      {rq, op, ad, dt, iq, n} = VEC[i];
      case (op)
        OP_W: wr(ad, dt);
        OP_R: rd(ad, dt, iq, $sformatf("R%0d vector %0d", rq, i));
        OP_T: ticks(int'(n));
        default: capture();
      endcase
    end

    // R6: wrap from all ones to zero sets overflow
    wr(3'd0, 8'h09);
    ticks(65536);
    rd(3'd0, 8'h0D, 1'b1, "R6 overflow set");
    rd(3'd3, 8'h00, 1'b1, "R6 wrapped count");
    wr(3'd0, 8'h0D);
    rd(3'd0, 8'h0D, 1'b1, "R6 write one keeps");
    wr(3'd0, 8'h09);
    rd(3'd0, 8'h09, 1'b0, "R6 write zero clears");

    // R9: capture and clearing write on the same edge
    capture();
    rd(3'd0, 8'h03, 1'b1, "R7 pending from capture");
    wr(3'd0, 8'h0A);
    rd(3'd0, 8'h0A, 1'b0, "R9 setup");
    @(negedge clk);
    cap_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 8'h08; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    cap_in = 1'b0;
    rd(3'd0, 8'h02, 1'b0, "R9 hardware set wins");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule